// File: doc/BRIEF.md
# Four-Step Leaping Galois Shift-Register Random Source

This block is a small pseudo-random bit source for control logic that needs a cheap, repeatable noise word every cycle, such as dither or test-pattern stimulus. It holds a 5-bit shift register in the Galois arrangement: on each shift, the bit that leaves one end is folded by XOR into a tapped stage. The feedback is fixed to the primitive polynomial x^5 + x^2 + 1, so the register walks through all 31 nonzero states before it repeats.

Single-step registers emit only one bit per clock. This block instead chains four copies of the one-step feedback as combinational logic. On every enabled clock edge it jumps ahead four shifts and registers the four bits that would have left the register during those shifts, as one parallel word. The stride of four has no common factor with 31, so the leaping register still visits every nonzero state.

The start state comes from a seed input, which is captured while reset is held. An all-zero seed would stall the register, so the block swaps it for a fixed nonzero value. The register state is brought out next to the random word so that it can be observed.

Top module: `lfsr_leap4_gen`

## Requirements
- R1: On a rising edge with `rst` high, `lfsr_state` takes the value of `seed` and `rnd_word` becomes 0. Both stay that way while `rst` stays high.
- R2: When a seed of all zeros is captured by reset, `lfsr_state` becomes 5'b00001 in its place.
- R3: One single shift of state s is defined as `(s >> 1) ^ (s[0] ? 5'b10100 : 5'b00000)`. The bit emitted by that shift is s[0].
- R4: On a rising edge with `rst` low and `en` high, `lfsr_state` takes the value that four successive single shifts (R3) give from its previous value.
- R5: On that same edge, `rnd_word` bit i takes the bit emitted by the (i+1)-th of those four shifts. Bit 0 holds the first emitted bit, so bits [2:0] equal the previous state bits [2:0].
- R6: On a rising edge with `rst` low and `en` low, `lfsr_state` and `rnd_word` keep their values, whatever `seed` does.
- R7: Starting from any nonzero state, `lfsr_state` first returns to that state after exactly 31 enabled updates, and it is never zero outside reset.
- R8: When `rst` and `en` are high on the same edge, reset takes priority (R1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| en | input | 1 | Advance the register four shifts on this edge |
| seed | input | 5 | Start state captured during reset |
| rnd_word | output | 4 | Four bits emitted by the last advance, first bit in bit 0 |
| lfsr_state | output | 5 | Current shift-register state |

## Verification
Two functions can fall in the same cycle: the seed load of reset and the four-step advance of enable. The bench provokes this by asserting `rst` and `en` together for every second seed. It judges the result by requiring the guarded seed and a zero word, with no trace of a leap. Hold is also checked against a changing seed: while `en` is low in the middle of a run, `seed` is given new values. The state and word must then stay frozen, and the run must continue exactly where it stopped.

// File: rtl/lfsr_leap_pkg.sv
package lfsr_leap_pkg;

    // Default configuration of the leaping generator.
    localparam int          LFSR_W    = 5;
    localparam int          LEAP_N    = 4;
    localparam logic [4:0]  FB_MASK   = 5'b10100;  // x^5 + x^2 + 1, right-shifting form
    localparam int          PERIOD    = (1 << LFSR_W) - 1;

endpackage

// File: rtl/lfsr_galois_step.sv
module lfsr_galois_step #(
    parameter int             W    = 5,
    parameter logic [W-1:0]   MASK = 5'b10100
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         bit_out
);

    // One right shift; the departing bit folds into the tapped stages.
    always_comb begin
        bit_out = cur[0];
        nxt     = (cur >> 1) ^ (cur[0] ? MASK : '0);
    end

endmodule

// File: rtl/lfsr_unroll.sv
module lfsr_unroll #(
    parameter int             W     = 5,
    parameter int             STEPS = 4,
    parameter logic [W-1:0]   MASK  = 5'b10100
) (
    input  logic [W-1:0]     start,
    output logic [W-1:0]     finish,
    output logic [STEPS-1:0] emitted
);

    logic [W-1:0] stage [0:STEPS];

    assign stage[0] = start;

    // Chain of single-shift cells; cell k yields emitted bit k.
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        lfsr_galois_step #(
            .W    (W),
            .MASK (MASK)
        ) u_step (
            .cur     (stage[k]),
            .nxt     (stage[k+1]),
            .bit_out (emitted[k])
        );
    end

    assign finish = stage[STEPS];

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
    parameter int W = 5
) (
    input  logic [W-1:0] seed_raw,
    output logic [W-1:0] seed_safe
);

    localparam logic [W-1:0] FALLBACK = {{(W-1){1'b0}}, 1'b1};

    // The all-zero state never leaves itself, so it is never loaded.
    always_comb begin
        seed_safe = (seed_raw == '0) ? FALLBACK : seed_raw;
    end

endmodule

// File: rtl/lfsr_leap4_gen.sv
module lfsr_leap4_gen
    import lfsr_leap_pkg::*;
#(
    parameter int             W     = LFSR_W,
    parameter int             STEPS = LEAP_N,
    parameter logic [W-1:0]   MASK  = FB_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [W-1:0]     seed,
    output logic [STEPS-1:0] rnd_word,
    output logic [W-1:0]     lfsr_state
);

    typedef struct packed {
        logic [W-1:0]     state;
        logic [STEPS-1:0] word;
    } gen_regs_t;

    gen_regs_t    regs_d, regs_q;
    logic [W-1:0] seed_ok;
    logic [W-1:0] leap_state;
    logic [STEPS-1:0] leap_bits;

    lfsr_seed_guard #(
        .W (W)
    ) u_guard (
        .seed_raw  (seed),
        .seed_safe (seed_ok)
    );

    lfsr_unroll #(
        .W     (W),
        .STEPS (STEPS),
        .MASK  (MASK)
    ) u_unroll (
        .start   (regs_q.state),
        .finish  (leap_state),
        .emitted (leap_bits)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.state = seed_ok;
            regs_d.word  = '0;
        end else if (en) begin
            regs_d.state = leap_state;
            regs_d.word  = leap_bits;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rnd_word   = regs_q.word;
    assign lfsr_state = regs_q.state;

endmodule

// File: rtl/lfsr_leap4_gen_chk.sv
module lfsr_leap4_gen_chk #(
    parameter int W     = 5,
    parameter int STEPS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [W-1:0]     seed,
    input logic [STEPS-1:0] word,
    input logic [W-1:0]     state
);

    // R1, R2, R8: a reset edge loads the guarded seed and clears the word.
    a_r1_seed_load: assert property (@(posedge clk)
        rst |=> (word == '0) &&
                (state == (($past(seed) == '0) ? {{(W-1){1'b0}}, 1'b1} : $past(seed))));

    // R5: the first three emitted bits are the old low state bits.
    a_r5_word_low_bits: assert property (@(posedge clk) disable iff (rst)
        en |=> word[2:0] == $past(state[2:0]));

    // R6: no enable, no change.
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state) && $stable(word));

    // R7: the register never reaches the lock-up state.
    a_r7_nonzero: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

bind lfsr_leap4_gen lfsr_leap4_gen_chk #(
    .W     (W),
    .STEPS (STEPS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .seed  (seed),
    .word  (rnd_word),
    .state (lfsr_state)
);

// File: tb/lfsr_leap4_gen_bench.sv
`timescale 1ns/1ps
module lfsr_leap4_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [4:0] seed = 5'd0;
    logic [3:0] rnd_word;
    logic [4:0] lfsr_state;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;  // 250 MHz

    lfsr_leap4_gen u_lfsr_leap4_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .seed       (seed),
        .rnd_word   (rnd_word),
        .lfsr_state (lfsr_state)
    );

    // Reference single shift from R3.
    function automatic logic [4:0] shift1(input logic [4:0] s);
        return {1'b0, s[4:1]} ^ (s[0] ? 5'b10100 : 5'b00000);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Inputs change 1 ns after the edge; outputs are read then too.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [4:0] st;
        logic [4:0] start;
        logic [3:0] exp_w;
        #1;
        for (int sd = 0; sd < 32; sd++) begin
            // R1/R8: reset, with enable also high for odd seeds.
            rst  = 1'b1;
            en   = sd[0];
            seed = sd[4:0];
            tick();
            start = (sd == 0) ? 5'b00001 : sd[4:0];
            check(sd == 0 ? "R2" : (sd[0] ? "R8" : "R1"), lfsr_state, start);
            check("R1", rnd_word, 4'd0);
            tick();
            check("R1", lfsr_state, start);
            rst = 1'b0;
            st  = start;
            for (int k = 1; k <= 31; k++) begin
                if (k % 3 == 2) begin
                    // R6: an idle edge with a scrambled seed.
                    en   = 1'b0;
                    seed = ~seed;
                    exp_w = rnd_word;
                    tick();
                    check("R6", lfsr_state, st);
                    check("R6", rnd_word, exp_w);
                end
                en = 1'b1;
                for (int j = 0; j < 4; j++) begin
                    exp_w[j] = st[0];
                    st = shift1(st);
                end
                tick();
                check("R4", lfsr_state, st);
                check("R5", rnd_word, exp_w);
                if (k < 31) begin
                    if (lfsr_state == start) check("R7", lfsr_state, ~start);
                    else                     check("R7", 1, 1);
                end else begin
                    check("R7", lfsr_state, start);
                end
            end
            en = 1'b0;
            exp_w = rnd_word;
            repeat (3) begin
                seed = seed + 5'd7;
                tick();
                check("R6", lfsr_state, start);
                check("R6", rnd_word, exp_w);
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule